// File: doc/BRIEF.md
# Write-Burst Cutoff and Read Turnaround Controller

This block sits on the controller side of a double-data-rate memory interface. It lets a pending read cut a write burst short. It also generates the per-byte data masks and the driver enables that make the cut safe. Write and read requests arrive as levels. Each clock carries two data words: word 0 goes with the rising strobe edge and word 1 with the falling edge. The block issues a WRITE or READ command code and passes the write data stream to the pins. It forces the mask on the words that sit around an interrupting read. It also releases the data and strobe drivers well before the read data comes back.

Cutting a burst is optional. It is only legal at lower interface clock rates, so an enable input can turn it off. With the enable off, a read waits until the write burst has finished, plus a last-data-to-read gap. Burst length and read latency are configuration inputs. They are captured with each command.

Top module: `wrrd_cutoff_ctrl`

## Requirements
- R1: After reset, the command code is NOP (0), and dq_oe, dqs_oe, wr_take, dq_out, dm_out and rd_window are all 0.
- R2: When wr_req is high, no burst is being driven, no read is pending, and the last read's data window plus one turnaround clock has passed, the block issues WRITE (code 1) in that clock with dqs_oe high as a preamble. The n data clocks that follow have dq_oe, dqs_oe and wr_take high, dq_out equal to wr_words, and dm_out equal to wr_mask_in. Here n is 1, 2 or 4 for cfg_bl codes 0, 1 and 2 or 3. In every clock that is not driven, dq_out and dm_out are 0.
- R3: With intr_en high, a rd_req seen in a data clock that leaves at least two data clocks (counting itself) makes READ (code 2) appear in the next clock. READ therefore never appears in the clock right after WRITE.
- R4: For an interrupting read, the clock before READ has both lanes of word 1 (dm_out bits [3:2]) forced high. The READ clock has all four mask bits forced high. Other driven clocks pass the input mask unchanged.
- R5: After an interrupting READ, no further words of that burst are driven: dq_oe, dqs_oe and wr_take stay low.
- R6: rd_window is high for exactly n clocks, starting cfg_cl clocks after READ. dq_oe and dqs_oe are low throughout the window and in the clock before it.
- R7: With intr_en low, a read that arrives during a write waits. READ appears no earlier than 2 clocks after the last data clock, and no mask bit is forced.
- R8: With intr_en high, a read first requested in the last data clock of a burst, or after it, is not an interruption. It is timed as in R7, and a 2-word burst is never interrupted.
- R9: After a READ, a WRITE is not issued until cfg_cl + n clocks after the READ.
- R10: Back-to-back reads with rd_req held are spaced by max(n, 2) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Write request, held until WRITE is seen |
| rd_req | input | 1 | Read request, held through the READ clock |
| intr_en | input | 1 | Allows reads to cut write bursts |
| cfg_bl | input | 2 | Burst length code: 0 = 2 words, 1 = 4 words, other = 8 words |
| cfg_cl | input | CL_W | Read latency in clocks (2 or more) |
| wr_words | input | 2*LANES*BYTE_W | Two write words for this clock, word 0 in the low half |
| wr_mask_in | input | 2*LANES | Input byte masks, word 0 lanes in the low bits |
| cmd_out | output | 2 | Issued command: 0 NOP, 1 WRITE, 2 READ |
| wr_take | output | 1 | The current clock consumes a data pair |
| dq_out | output | 2*LANES*BYTE_W | Data driven this clock |
| dm_out | output | 2*LANES | Byte masks driven with the data |
| dq_oe | output | 1 | Data driver enable |
| dqs_oe | output | 1 | Strobe driver enable |
| rd_window | output | 1 | Read data is expected on the bus |

## Verification
The bench sweeps every burst length, two read latencies, both enable settings, and a read request placed at every offset across and beyond the write burst. This puts the request on the first data clock, on the last one, and in the gap after it. A controller that decided the cut one clock late would leave the pre-read word unmasked. One that cut in the final data clock would corrupt a word that was meant to be written. One that kept driving after the cut would collide with the returning read data. Follow-up writes and back-to-back reads catch a turnaround counter that is short by one, and a 2-word burst catches a read that slips into the clock right after WRITE.

// File: rtl/wrrd_pkg.sv
package wrrd_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_READ  = 2'd2
  } wrrd_cmd_e;

  // Data clocks (word pairs) per burst for a burst length code.
  function automatic logic [2:0] bl_clocks(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // True when an issue seen k clocks ago lands in the read data window.
  function automatic bit in_read_window(input int k, input int cl, input int n);
    return (k >= cl) && (k < cl + n);
  endfunction

endpackage

// File: rtl/wrrd_wburst.sv
// Write burst tracker: counts the data clocks left in the burst and the
// last-data-to-read gap that follows it.
module wrrd_wburst
  import wrrd_pkg::*;
#(
  parameter int CDLR = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_issue,
  input  logic       cut,
  input  logic [1:0] bl_code,
  output logic       data_active,
  output logic       two_left,
  output logic       gap_clear
);
  localparam int GAP_W = (CDLR < 2) ? 1 : $clog2(CDLR + 1);

  logic [2:0]       wcnt;
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= '0;
      gap  <= '0;
    end else begin
      if (wr_issue)          wcnt <= bl_clocks(bl_code);
      else if (cut)          wcnt <= '0;          // R5: rest of burst dropped
      else if (wcnt != 3'd0) wcnt <= wcnt - 3'd1;

      if (wcnt == 3'd1 && !cut) gap <= GAP_W'(CDLR - 1);  // R7 gap
      else if (gap != '0)       gap <= gap - 1'b1;
    end
  end

  always_comb begin
    data_active = (wcnt != 3'd0);
    two_left    = (wcnt >= 3'd2);
    gap_clear   = (wcnt == 3'd0) && (gap == '0);
  end

endmodule

// File: rtl/wrrd_rsched.sv
// Read scheduler: decides one clock ahead, so the pre-read word can be masked.
module wrrd_rsched
  import wrrd_pkg::*;
#(
  parameter int CL_W  = 3,
  parameter int CNT_W = 4,
  parameter int DEPTH = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_req,
  input  logic            intr_en,
  input  logic            two_left,
  input  logic            gap_clear,
  input  logic [CL_W-1:0] cl,
  input  logic [1:0]      bl_code,
  output logic            rd_decide,
  output logic            rd_intr,
  output logic            rd_issue,
  output logic            rd_cut,
  output logic            wr_block,
  output logic            rd_window
);
  logic [2:0]       n_now;
  logic [2:0]       hold;
  logic             rd_go;
  logic             cut_q;
  logic [CNT_W-1:0] busy;
  logic [CL_W-1:0]  cl_q;
  logic [2:0]       n_q;
  logic [DEPTH:1]   hist;
  logic             intr_path;

  always_comb begin
    n_now     = bl_clocks(bl_code);
    intr_path = intr_en && two_left;                           // R3, R8
    rd_decide = rd_req && (hold == 3'd0) && !rd_go && (intr_path || gap_clear);
    rd_intr   = rd_decide && intr_path;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold  <= '0;
      rd_go <= 1'b0;
      cut_q <= 1'b0;
      busy  <= '0;
      cl_q  <= '0;
      n_q   <= '0;
      hist  <= '0;
    end else begin
      rd_go <= rd_decide;
      cut_q <= rd_intr;
      hist  <= {hist[DEPTH-1:1], rd_go};
      if (rd_decide) begin
        hold <= n_now - 3'd1;                                  // R10 spacing
        busy <= CNT_W'(cl) + CNT_W'(n_now);                    // R9 turnaround
        cl_q <= cl;
        n_q  <= n_now;
      end else begin
        if (hold != 3'd0) hold <= hold - 3'd1;
        if (busy != '0)   busy <= busy - 1'b1;
      end
    end
  end

  always_comb begin
    rd_window = 1'b0;                                          // R6
    for (int k = 1; k <= DEPTH; k++) begin
      if (hist[k] && in_read_window(k, int'(cl_q), int'(n_q))) rd_window = 1'b1;
    end
  end

  assign rd_issue = rd_go;
  assign rd_cut   = cut_q;
  assign wr_block = rd_req || rd_go || (busy != '0);

  // R10: two READ commands never sit in adjacent clocks
  a_r10_no_adjacent_reads: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |=> !rd_issue);

endmodule

// File: rtl/wrrd_maskgen.sv
// Data path: drives the words and merges the forced masks around a cut.
module wrrd_maskgen #(
  parameter int LANES  = 2,
  parameter int WORD_W = 16
) (
  input  logic                  data_active,
  input  logic                  wr_issue,
  input  logic                  rd_intr,
  input  logic                  rd_cut,
  input  logic [2*WORD_W-1:0]   wr_words,
  input  logic [2*LANES-1:0]    wr_mask_in,
  output logic [2*WORD_W-1:0]   dq_out,
  output logic [2*LANES-1:0]    dm_out,
  output logic                  dq_oe,
  output logic                  dqs_oe,
  output logic                  wr_take
);
  for (genvar s = 0; s < 2; s++) begin : g_slot
    logic force_m;
    // R4: word 1 before the read and both words in the read clock
    assign force_m = rd_cut | ((s == 1) ? rd_intr : 1'b0);
    assign dm_out[s*LANES +: LANES] = data_active ?
             (wr_mask_in[s*LANES +: LANES] | {LANES{force_m}}) : '0;
    assign dq_out[s*WORD_W +: WORD_W] = data_active ?
             wr_words[s*WORD_W +: WORD_W] : '0;
  end

  assign dq_oe   = data_active;
  assign dqs_oe  = data_active | wr_issue;   // R2 preamble in the command clock
  assign wr_take = data_active;

endmodule

// File: rtl/wrrd_cutoff_ctrl.sv
module wrrd_cutoff_ctrl
  import wrrd_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int BYTE_W = 8,
  parameter int CL_W   = 3,
  parameter int CDLR   = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_req,
  input  logic                        rd_req,
  input  logic                        intr_en,
  input  logic [1:0]                  cfg_bl,
  input  logic [CL_W-1:0]             cfg_cl,
  input  logic [2*LANES*BYTE_W-1:0]   wr_words,
  input  logic [2*LANES-1:0]          wr_mask_in,
  output logic [1:0]                  cmd_out,
  output logic                        wr_take,
  output logic [2*LANES*BYTE_W-1:0]   dq_out,
  output logic [2*LANES-1:0]          dm_out,
  output logic                        dq_oe,
  output logic                        dqs_oe,
  output logic                        rd_window
);
  localparam int WORD_W = LANES * BYTE_W;
  localparam int CL_MAX = (1 << CL_W) - 1;
  localparam int DEPTH  = CL_MAX + 4;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic data_active, two_left, gap_clear;
  logic rd_decide, rd_intr, rd_issue, rd_cut, wr_block;
  logic wr_issue;

  assign wr_issue = wr_req && !wr_block && !data_active;       // R2, R9

  always_comb begin
    if (wr_issue)      cmd_out = CMD_WRITE;
    else if (rd_issue) cmd_out = CMD_READ;
    else               cmd_out = CMD_NOP;
  end

  wrrd_wburst #(.CDLR(CDLR)) u_wburst (
    .clk(clk), .rst_n(rst_n), .wr_issue(wr_issue), .cut(rd_cut),
    .bl_code(cfg_bl), .data_active(data_active), .two_left(two_left),
    .gap_clear(gap_clear)
  );

  wrrd_rsched #(.CL_W(CL_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_rsched (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .intr_en(intr_en),
    .two_left(two_left), .gap_clear(gap_clear), .cl(cfg_cl), .bl_code(cfg_bl),
    .rd_decide(rd_decide), .rd_intr(rd_intr), .rd_issue(rd_issue),
    .rd_cut(rd_cut), .wr_block(wr_block), .rd_window(rd_window)
  );

  wrrd_maskgen #(.LANES(LANES), .WORD_W(WORD_W)) u_maskgen (
    .data_active(data_active), .wr_issue(wr_issue), .rd_intr(rd_intr),
    .rd_cut(rd_cut), .wr_words(wr_words), .wr_mask_in(wr_mask_in),
    .dq_out(dq_out), .dm_out(dm_out), .dq_oe(dq_oe), .dqs_oe(dqs_oe),
    .wr_take(wr_take)
  );

  // R3: a READ never follows a WRITE in the next clock
  a_r3_no_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out == CMD_READ) |-> ($past(cmd_out) != CMD_WRITE));

  // R4: a READ that lands inside a driven burst carries a full mask
  a_r4_read_clock_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out == CMD_READ && dq_oe) |-> (&dm_out));

  // R5: once a read cuts the burst, drive stops the next clock
  a_r5_cut_stops_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out == CMD_READ && dq_oe) |=> (!dq_oe && !dqs_oe && !wr_take));

  // R6: buses are released during read data and one clock ahead of it
  a_r6_no_drive_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    rd_window |-> (!dq_oe && !dqs_oe));
  a_r6_released_early: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_window) |-> (!$past(dq_oe) && !$past(dqs_oe)));

  // R9: no WRITE while read data is returning
  a_r9_no_write_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    rd_window |-> (cmd_out != CMD_WRITE));

endmodule

// File: tb/wrrd_cutoff_ctrl_test.sv
module wrrd_cutoff_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_req = 1'b0, rd_req = 1'b0, intr_en = 1'b0;
  logic [1:0]  cfg_bl = 2'd0;
  logic [2:0]  cfg_cl = 3'd2;
  logic [31:0] wr_words = '0;
  logic [3:0]  wr_mask_in = '0;
  logic [1:0]  cmd_out;
  logic        wr_take, dq_oe, dqs_oe, rd_window;
  logic [31:0] dq_out;
  logic [3:0]  dm_out;

  int checks = 0, errors = 0, gcyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wrrd_cutoff_ctrl #(.LANES(2), .BYTE_W(8), .CL_W(3), .CDLR(1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req), .intr_en(intr_en),
    .cfg_bl(cfg_bl), .cfg_cl(cfg_cl), .wr_words(wr_words), .wr_mask_in(wr_mask_in),
    .cmd_out(cmd_out), .wr_take(wr_take), .dq_out(dq_out), .dm_out(dm_out),
    .dq_oe(dq_oe), .dqs_oe(dqs_oe), .rd_window(rd_window)
  );

  task automatic chk(input string tag, input string what, input int t,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s t=%0d act=%0h exp=%0h", tag, what, t, act, exp);
    end
  endtask

  task automatic new_data();
    gcyc++;
    wr_words   = {gcyc[15:0] ^ 16'hA5A5, gcyc[15:0]};
    wr_mask_in = gcyc[3:0];
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      wr_req = 1'b0; rd_req = 1'b0;
      new_data();
    end
  endtask

  // Write at t=0, read requested from t=off, then a follow-up write.
  task automatic run_wr(input int blc, input int cl, input bit en, input int off);
    int n, L, D, R, W, last, len;
    bit intr;
    string rtag;
    n = 1 << blc; L = n;
    if (en && off <= L - 1) begin intr = 1; D = off; end
    else begin intr = 0; D = (off > L + 1) ? off : L + 1; end
    R = D + 1; W = R + cl + n; last = intr ? R : L; len = W + n + 3;
    rtag = intr ? "R3" : (en ? "R8" : "R7");
    cfg_bl = blc[1:0]; cfg_cl = cl[2:0]; intr_en = en;
    for (int t = 0; t <= len; t++) begin
      logic [1:0] ecmd;
      bit eoe, edqs, ewin;
      logic [3:0] edm;
      logic [31:0] edq;
      @(negedge clk);
      new_data();
      wr_req = (t == 0) || (t > R && t <= W);
      rd_req = (t >= off) && (t <= R);
      #1;
      ecmd = (t == 0 || t == W) ? 2'd1 : (t == R) ? 2'd2 : 2'd0;
      eoe  = (t >= 1 && t <= last) || (t >= W + 1 && t <= W + n);
      edqs = eoe || t == 0 || t == W;
      ewin = (t >= R + cl) && (t <= R + cl + n - 1);
      edm  = wr_mask_in;
      if (intr && t == D) edm = edm | 4'b1100;
      if (intr && t == R) edm = 4'hF;
      if (!eoe) edm = 4'h0;
      edq  = eoe ? wr_words : 32'h0;
      chk((t == R) ? rtag : (t == W) ? "R9" : "R2", "cmd", t, 32'(cmd_out), 32'(ecmd));
      chk((intr && t > R) ? "R5" : "R2", "dq_oe", t, 32'(dq_oe), 32'(eoe));
      chk((intr && t > R) ? "R5" : "R2", "dqs_oe", t, 32'(dqs_oe), 32'(edqs));
      chk("R5", "wr_take", t, 32'(wr_take), 32'(eoe));
      chk("R4", "dm", t, 32'(dm_out), 32'(edm));
      chk("R2", "dq", t, dq_out, edq);
      chk("R6", "rd_window", t, 32'(rd_window), 32'(ewin));
    end
    idle(2);
  endtask

  // Two reads with rd_req held from an idle bus.
  task automatic run_rr(input int blc, input int cl);
    int n, R1, R2, len;
    n = 1 << blc; R1 = 1; R2 = 1 + ((n > 2) ? n : 2); len = R2 + cl + n + 2;
    cfg_bl = blc[1:0]; cfg_cl = cl[2:0]; intr_en = 1'b1;
    for (int t = 0; t <= len; t++) begin
      logic [1:0] ecmd;
      bit ewin;
      @(negedge clk);
      new_data();
      wr_req = 1'b0;
      rd_req = (t <= R2);
      #1;
      ecmd = (t == R1 || t == R2) ? 2'd2 : 2'd0;
      ewin = (t >= R1 + cl && t <= R1 + cl + n - 1) || (t >= R2 + cl && t <= R2 + cl + n - 1);
      chk("R10", "cmd", t, 32'(cmd_out), 32'(ecmd));
      chk("R6", "rd_window", t, 32'(rd_window), 32'(ewin));
      chk("R6", "dq_oe", t, 32'(dq_oe), 32'h0);
    end
    idle(cl + n + 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", "cmd", 0, 32'(cmd_out), 32'h0);
    chk("R1", "dq_oe", 0, 32'(dq_oe), 32'h0);
    chk("R1", "dqs_oe", 0, 32'(dqs_oe), 32'h0);
    chk("R1", "wr_take", 0, 32'(wr_take), 32'h0);
    chk("R1", "dm", 0, 32'(dm_out), 32'h0);
    chk("R1", "dq", 0, dq_out, 32'h0);
    chk("R1", "rd_window", 0, 32'(rd_window), 32'h0);
    idle(2);
    for (int blc = 0; blc < 3; blc++)
      for (int cl = 2; cl <= 3; cl++)
        for (int en = 0; en < 2; en++)
          for (int off = 1; off <= (1 << blc) + 3; off++)
            run_wr(blc, cl, en[0], off);
    for (int blc = 0; blc < 3; blc++)
      for (int cl = 2; cl <= 3; cl++)
        run_rr(blc, cl);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule